// File: doc/BRIEF.md
# Line Pulse Generator

This block produces every line-rate timing pulse for a 441-line interlaced raster from a single master clock. A prescaler, set by a 2-bit select, turns the master clock into a pixel-step enable at 256 steps per line, so the master clock may run at 256, 512 or 1024 times the line rate. An 8-bit counter advances on each step and wraps once per line.

A segment state machine follows the counter through the line and drives the outputs: horizontal sync, horizontal blanking, horizontal drive (front porch plus sync), a back-porch clamp, and a strobe at twice the line rate for the field logic. The step enable is also brought out. The states are ACTIVE (picture), FRONT (front porch), SYNC, POST (gap after sync), CLAMP and TAIL (end of blanking). The transitions are:

- ACTIVE to FRONT when the count reaches 22.
- FRONT to SYNC at 25.
- SYNC to POST at 50.
- POST to CLAMP at 52.
- CLAMP to TAIL at 66.
- TAIL to ACTIVE at 68.
- Any state to ACTIVE on a line reset or global reset.

A synchronous line-reset input restarts the line, so that several generators can be locked together.

Top module: `line_pulse_gen`

## Requirements
- R1: The select code sets the prescale ratio. Code 0 divides by 1, code 1 divides by 2, and codes 2 and 3 divide by 4. `pix_tick` pulses for one master cycle, once every ratio cycles, in the cycle after the line count has advanced. If the select changes while the prescale count is already at or above the new limit, the count advances at the next edge.
- R2: The line count steps by one per `pix_tick` and wraps from 255 to 0, so each line lasts 256 ticks. Consecutive `half_line` pulses are 128 ticks apart.
- R3: `hsync` is high exactly while the line count is in 25..49.
- R4: `hblank` is high exactly while the line count is in 22..67.
- R5: `hdrive` is high exactly while the line count is in 22..49.
- R6: `clamp` is high exactly while the line count is in 52..65.
- R7: `half_line` is high for one master cycle, in the cycle after the count steps to 0 or to 128.
- R8: When `line_rst` is high at an edge, the line count and the prescale count go to 0 and no tick or strobe is issued. The next tick follows the full prescale ratio after `line_rst` falls.
- R9: When `rst` is high at an edge, all outputs go low, and the count and prescale restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous global reset, active high |
| line_rst | input | 1 | Synchronous line restart, active high |
| clk_sel | input | 2 | Prescale select: 0 is ÷1, 1 is ÷2, 2 and 3 are ÷4 |
| pix_tick | output | 1 | Pixel-step pulse at 256 times the line rate |
| hsync | output | 1 | Horizontal sync |
| hblank | output | 1 | Horizontal blanking |
| hdrive | output | 1 | Horizontal drive (front porch and sync) |
| clamp | output | 1 | Back-porch clamp |
| half_line | output | 1 | Strobe at twice the line rate |

## Verification
The outputs are compared every master cycle with an arithmetic model of the count, over full lines at each of the four select codes. The ÷1 runs expose window-edge errors with no slack. The ÷2 and ÷4 runs show whether decode and strobes stay tied to count steps rather than to master cycles. Line resets are applied mid-line and across a select change, and a global reset is applied mid-run. These separate the restart behaviour from the free-running wrap. The spacing between strobes confirms the 256-step line.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    typedef enum logic [1:0] {
        SEL_DIV1  = 2'd0,
        SEL_DIV2  = 2'd1,
        SEL_DIV4  = 2'd2,
        SEL_DIV4B = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        SEG_ACTIVE,
        SEG_FRONT,
        SEG_SYNC,
        SEG_POST,
        SEG_CLAMP,
        SEG_TAIL
    } seg_e;

endpackage

// File: rtl/lpg_prescaler.sv
module lpg_prescaler
    import lpg_pkg::*;
#(
    parameter int PRE_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_rst,
    input  logic [1:0] clk_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (sel_e'(clk_sel))
            SEL_DIV1:  limit = PRE_W'(0);
            SEL_DIV2:  limit = PRE_W'(1);
            SEL_DIV4,
            SEL_DIV4B: limit = PRE_W'(3);
            default:   limit = PRE_W'(0);
        endcase
    end

    assign tick = !line_rst && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || line_rst || tick) pre_q <= '0;
        else                         pre_q <= pre_q + 1'b1;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && clk_sel != 2'd0) |=> (!tick || clk_sel == 2'd0));

    // R8
    lr_pre_chk: assert property (@(posedge clk) disable iff (rst)
        line_rst |=> (pre_q == '0));

endmodule

// File: rtl/lpg_line_counter.sv
module lpg_line_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_d,
    output logic             pix_q,
    output logic             half_q
);
    localparam int STEPS = 1 << CNT_W;
    localparam logic [CNT_W-1:0] HALF = CNT_W'(STEPS / 2);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (line_rst)  cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pix_q  <= 1'b0;
            half_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pix_q  <= tick;
            half_q <= tick && (cnt_d == '0 || cnt_d == HALF);
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !line_rst) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8
    lr_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        line_rst |=> (cnt_q == '0 && !half_q && !pix_q));

    // R7
    half_pos_chk: assert property (@(posedge clk) disable iff (rst)
        half_q |-> (pix_q && (cnt_q == '0 || cnt_q == HALF)));

endmodule

// File: rtl/lpg_segment_fsm.sv
module lpg_segment_fsm
    import lpg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int BLANK_START = 22,
    parameter int SYNC_START  = 25,
    parameter int SYNC_LAST   = 49,
    parameter int CLAMP_START = 52,
    parameter int CLAMP_LAST  = 65,
    parameter int BLANK_LAST  = 67
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_rst,
    input  logic [CNT_W-1:0] cnt_d,
    output logic             hsync_q,
    output logic             hblank_q,
    output logic             hdrive_q,
    output logic             clamp_q
);
    localparam logic [CNT_W-1:0] AT_FRONT = CNT_W'(BLANK_START);
    localparam logic [CNT_W-1:0] AT_SYNC  = CNT_W'(SYNC_START);
    localparam logic [CNT_W-1:0] AT_POST  = CNT_W'(SYNC_LAST + 1);
    localparam logic [CNT_W-1:0] AT_CLAMP = CNT_W'(CLAMP_START);
    localparam logic [CNT_W-1:0] AT_TAIL  = CNT_W'(CLAMP_LAST + 1);
    localparam logic [CNT_W-1:0] AT_END   = CNT_W'(BLANK_LAST + 1);

    seg_e seg_q, seg_d;

    always_comb begin
        seg_d = seg_q;
        if (line_rst) begin
            seg_d = SEG_ACTIVE;
        end else begin
            unique case (seg_q)
                SEG_ACTIVE: if (cnt_d == AT_FRONT) seg_d = SEG_FRONT;
                SEG_FRONT:  if (cnt_d == AT_SYNC)  seg_d = SEG_SYNC;
                SEG_SYNC:   if (cnt_d == AT_POST)  seg_d = SEG_POST;
                SEG_POST:   if (cnt_d == AT_CLAMP) seg_d = SEG_CLAMP;
                SEG_CLAMP:  if (cnt_d == AT_TAIL)  seg_d = SEG_TAIL;
                SEG_TAIL:   if (cnt_d == AT_END)   seg_d = SEG_ACTIVE;
                default:    seg_d = SEG_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seg_q <= SEG_ACTIVE;
        else     seg_q <= seg_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_q  <= 1'b0;
            hblank_q <= 1'b0;
            hdrive_q <= 1'b0;
            clamp_q  <= 1'b0;
        end else begin
            hsync_q  <= 1'b0;
            hblank_q <= 1'b1;
            hdrive_q <= 1'b0;
            clamp_q  <= 1'b0;
            unique case (seg_d)
                SEG_ACTIVE: hblank_q <= 1'b0;
                SEG_FRONT:  hdrive_q <= 1'b1;
                SEG_SYNC: begin
                    hsync_q  <= 1'b1;
                    hdrive_q <= 1'b1;
                end
                SEG_CLAMP:  clamp_q  <= 1'b1;
                SEG_POST, SEG_TAIL: ;
                default:    hblank_q <= 1'b0;
            endcase
        end
    end

    // R3
    sync_nest_chk: assert property (@(posedge clk) disable iff (rst)
        hsync_q |-> (hblank_q && hdrive_q));

    // R6
    clamp_apart_chk: assert property (@(posedge clk) disable iff (rst)
        clamp_q |-> (hblank_q && !hsync_q && !hdrive_q));

    // R5
    drive_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hdrive_q |-> hblank_q);

endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen #(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 2,
    parameter int BLANK_START = 22,
    parameter int SYNC_START  = 25,
    parameter int SYNC_LAST   = 49,
    parameter int CLAMP_START = 52,
    parameter int CLAMP_LAST  = 65,
    parameter int BLANK_LAST  = 67
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_rst,
    input  logic [1:0] clk_sel,
    output logic       pix_tick,
    output logic       hsync,
    output logic       hblank,
    output logic       hdrive,
    output logic       clamp,
    output logic       half_line
);
    logic             tick;
    logic [CNT_W-1:0] cnt_d;

    lpg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .line_rst (line_rst),
        .clk_sel  (clk_sel),
        .tick     (tick)
    );

    lpg_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .line_rst (line_rst),
        .tick     (tick),
        .cnt_d    (cnt_d),
        .pix_q    (pix_tick),
        .half_q   (half_line)
    );

    lpg_segment_fsm #(
        .CNT_W       (CNT_W),
        .BLANK_START (BLANK_START),
        .SYNC_START  (SYNC_START),
        .SYNC_LAST   (SYNC_LAST),
        .CLAMP_START (CLAMP_START),
        .CLAMP_LAST  (CLAMP_LAST),
        .BLANK_LAST  (BLANK_LAST)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .line_rst (line_rst),
        .cnt_d    (cnt_d),
        .hsync_q  (hsync),
        .hblank_q (hblank),
        .hdrive_q (hdrive),
        .clamp_q  (clamp)
    );

    // R4
    blank_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hsync) && !$past(line_rst)) |-> hblank && $past(hblank));

endmodule

// File: tb/test_line_pulse_gen.sv
module test_line_pulse_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_rst = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       pix_tick, hsync, hblank, hdrive, clamp, half_line;

    always #4 clk = ~clk;

    line_pulse_gen i_line_pulse_gen (
        .clk(clk), .rst(rst), .line_rst(line_rst), .clk_sel(clk_sel),
        .pix_tick(pix_tick), .hsync(hsync), .hblank(hblank),
        .hdrive(hdrive), .clamp(clamp), .half_line(half_line)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Arithmetic model of the requirements
    int m_pre = 0, m_cnt = 0, m_tick = 0, m_half = 0;
    bit m_in_rst = 1'b1;
    int since_lr = 1000;

    always @(posedge clk) begin
        int div;
        int t;
        div = (clk_sel == 2'd0) ? 1 : (clk_sel == 2'd1) ? 2 : 4;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_tick = 0; m_half = 0; m_in_rst = 1'b1;
        end else begin
            m_in_rst = 1'b0;
            if (line_rst) begin
                m_pre = 0; m_cnt = 0; m_tick = 0; m_half = 0; since_lr = 0;
            end else begin
                if (since_lr < 1000) since_lr++;
                t = (m_pre >= div - 1) ? 1 : 0;
                m_pre = t ? 0 : m_pre + 1;
                if (t) m_cnt = (m_cnt + 1) % 256;
                m_tick = t;
                m_half = (t && (m_cnt == 0 || m_cnt == 128)) ? 1 : 0;
            end
        end
    end

    // R2 spacing of strobes
    int  ticks_since = 0;
    bit  spacing_ok = 1'b0;

    always @(negedge clk) begin
        string tg;
        if (m_in_rst) begin
            chk(pix_tick == 0 && hsync == 0 && hblank == 0 && hdrive == 0 &&
                clamp == 0 && half_line == 0, "R9",
                {pix_tick, hsync, hblank, hdrive, clamp, half_line}, 0);
            spacing_ok = 1'b0;
            ticks_since = 0;
        end else begin
            tg = (since_lr < 8) ? "R8" : "";
            chk(pix_tick == m_tick, (tg != "") ? tg : "R1", pix_tick, m_tick);
            chk(hsync == (m_cnt >= 25 && m_cnt <= 49), (tg != "") ? tg : "R3",
                hsync, (m_cnt >= 25 && m_cnt <= 49));
            chk(hblank == (m_cnt >= 22 && m_cnt <= 67), (tg != "") ? tg : "R4",
                hblank, (m_cnt >= 22 && m_cnt <= 67));
            chk(hdrive == (m_cnt >= 22 && m_cnt <= 49), (tg != "") ? tg : "R5",
                hdrive, (m_cnt >= 22 && m_cnt <= 49));
            chk(clamp == (m_cnt >= 52 && m_cnt <= 65), (tg != "") ? tg : "R6",
                clamp, (m_cnt >= 52 && m_cnt <= 65));
            chk(half_line == m_half, (tg != "") ? tg : "R7", half_line, m_half);
            if (since_lr == 0) begin
                spacing_ok = 1'b0;
                ticks_since = 0;
            end else begin
                if (pix_tick) ticks_since++;
                if (half_line) begin
                    if (spacing_ok) chk(ticks_since == 128, "R2", ticks_since, 128);
                    spacing_ok = 1'b1;
                    ticks_since = 0;
                end
            end
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        clk_sel = 2'd0;  run(700);
        clk_sel = 2'd1;  run(900);
        line_rst = 1'b1; run(1);
        line_rst = 1'b0; run(700);
        clk_sel = 2'd2;  run(2200);
        line_rst = 1'b1; clk_sel = 2'd3; run(2);
        line_rst = 1'b0; run(1100);
        clk_sel = 2'd0;  run(300);
        rst = 1'b1;      run(2);
        rst = 1'b0;      run(600);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule